// File: doc/BRIEF.md
# MDIO Management Master with Single Command Register

This block lets a host reach PHY management registers through one 32-bit control word. The host writes a PHY address, a register address, a direction bit, 16 bits of write data and two flags: enable and go/busy. When the word is accepted, the block runs one clause-22 management frame on MDC/MDIO. The busy flag stays set for the whole frame and then clears by itself. After a read, the low half-word of the same register holds the value the PHY returned.

PHY addresses at or above the parameter `NUM_PHY` are treated as absent. A command aimed at such an address finishes in the cycle it is written, and no frame is driven. MDC is derived from the system clock by an even divide ratio `CLK_DIV`, and it is held low between frames.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, `ctrl_o` reads 0, `mdc_o` is low and `mdio_oe_o` is low.
- R2: `ctrl_o` layout: [15:0] data, [20:16] register address, [25:21] PHY address, [27] direction (1 = read, 0 = write), [30] enable, [31] busy, all other bits 0. An accepted write stores every field.
- R3: A write arriving while busy reads 1 is ignored. Every register field keeps its value and the running frame continues.
- R4: A write with only one of bit 31 and bit 30 set stores its fields, starts no frame and leaves busy at 0.
- R5: A frame is sent MSB first: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, a 2-bit turnaround (10 on writes), then 16 data bits.
- R6: Each frame bit lasts `CLK_DIV` system clocks. MDC is low for the first half of the bit and high for the second half, and it stays low while the block is not busy.
- R7: On a read, `mdio_oe_o` is asserted for frame bits 0..45 and released for the turnaround and data bits (46..63). `mdio_i` is sampled in the first clock of each MDC high phase of bits 48..63, and the 16 bits go to [15:0] in the cycle busy clears.
- R8: On a write, `mdio_oe_o` is asserted for the whole frame, and [15:0] still holds the written data after completion.
- R9: A command with bits 31 and 30 set and a PHY address of `NUM_PHY` or more reads back with busy 0 in the next cycle. `mdio_oe_o` is never asserted for it. For a read, [15:0] becomes 0xFFFF.
- R10: A valid command keeps busy at 1 for exactly 64 × `CLK_DIV` clocks, counted from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the control word |
| wr_data_i | input | 32 | Control word written by the host |
| ctrl_o | output | 32 | Control word readback, including busy and read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Several properties are checked by assertions on every cycle: MDC and the output enable stay low whenever the block is idle, a write during busy leaves the address and flag fields unchanged, a rejected PHY address never raises busy, and the output enable is released during the read data window. Other behaviour is shown only by the bench scenarios, which compare against a cycle-level model. These cover the exact bit order of each frame, the sampling instant of the returned bits, the length of the busy window and the 0xFFFF fill for absent PHYs.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;

  typedef struct packed {
    logic        busy;
    logic        en;
    logic [1:0]  rsv_hi;
    logic        rd;
    logic        rsv_lo;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] data;
  } ctrl_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic rd, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
            (rd ? 2'b11 : 2'b10), wd};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic smp_o,
  output logic bit_end_o
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(CLK_DIV / 2);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i || cnt_q == LAST_C)   cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  assign mdc_o     = run_i && (cnt_q >= HALF_C);
  assign smp_o     = run_i && (cnt_q == HALF_C);
  assign bit_end_o = run_i && (cnt_q == LAST_C);

  // R6
  mdc_low_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> !mdc_o);
  // R6
  mdc_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  ra_i,
  input  logic [15:0] wd_i,
  input  logic        smp_i,
  input  logic        bit_end_i,
  input  logic        mdio_i,
  output logic        active_o,
  output logic        done_o,
  output logic        mdio_o,
  output logic        oe_o,
  output logic [15:0] rdata_o
);
  localparam logic [5:0] LAST_IDX = 6'(FRAME_BITS - 1);

  logic                  active_q, rd_q;
  logic [5:0]            idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [15:0]           rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      rdata_q  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rd_q     <= rd_i;
      idx_q    <= '0;
      sh_q     <= build_frame(rd_i, phy_i, ra_i, wd_i);
    end else if (active_q) begin
      if (smp_i && rd_q && idx_q >= 6'(DATA_BIT))
        rdata_q <= {rdata_q[14:0], mdio_i};
      if (bit_end_i) begin
        if (idx_q == LAST_IDX) active_q <= 1'b0;
        else                   idx_q    <= idx_q + 1'b1;
        sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = active_q && bit_end_i && (idx_q == LAST_IDX);
  assign oe_o     = active_q && !(rd_q && idx_q >= 6'(TA_BIT));
  assign mdio_o   = active_q && sh_q[FRAME_BITS-1];
  assign rdata_o  = rdata_q;

  // R3
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  // R7
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && rd_q && idx_q >= 6'(DATA_BIT)) |-> !oe_o);
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int NUM_PHY = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ctrl_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam logic [5:0] PHY_LIM = 6'(NUM_PHY);

  ctrl_t       wcmd, rd_back;
  logic        busy, done, smp, bit_end, accept, go, phy_ok, start;
  logic        en_q, rd_q;
  logic [4:0]  phy_q, ra_q;
  logic [15:0] data_q, rdata;
  logic        unused_bits;

  assign wcmd        = ctrl_t'(wr_data_i);
  assign unused_bits = ^{wcmd.rsv_hi, wcmd.rsv_lo};
  assign go          = wcmd.busy && wcmd.en;
  assign phy_ok      = {1'b0, wcmd.phy} < PHY_LIM;
  assign accept      = wr_en_i && !busy;
  assign start       = accept && go && phy_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; rd_q <= 1'b0; phy_q <= '0; ra_q <= '0; data_q <= '0;
    end else if (accept) begin
      en_q   <= wcmd.en;
      rd_q   <= wcmd.rd;
      phy_q  <= wcmd.phy;
      ra_q   <= wcmd.ra;
      data_q <= (go && !phy_ok && wcmd.rd) ? 16'hFFFF : wcmd.data;
    end else if (done && rd_q) begin
      data_q <= rdata;
    end
  end

  always_comb begin
    rd_back        = '0;
    rd_back.busy   = busy;
    rd_back.en     = en_q;
    rd_back.rd     = rd_q;
    rd_back.phy    = phy_q;
    rd_back.ra     = ra_q;
    rd_back.data   = data_q;
  end
  assign ctrl_o = rd_back;

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk_i, .rst_ni, .run_i(busy), .mdc_o, .smp_o(smp), .bit_end_o(bit_end)
  );

  mdio_frame_shift u_shift (
    .clk_i, .rst_ni, .start_i(start), .rd_i(wcmd.rd), .phy_i(wcmd.phy),
    .ra_i(wcmd.ra), .wd_i(wcmd.data), .smp_i(smp), .bit_end_i(bit_end),
    .mdio_i, .active_o(busy), .done_o(done), .mdio_o, .oe_o(mdio_oe_o),
    .rdata_o(rdata)
  );

  // R6
  mdc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  // R9
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdio_oe_o);
  // R3
  ignore_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_en_i) |=> $stable(ctrl_o[30:16]));
  // R9
  bad_phy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && go && !phy_ok) |=> !ctrl_o[31]);
endmodule

// File: tb/tb_mdio_cmd_master.sv
module tb_mdio_cmd_master;
  localparam int DIV = 4;
  localparam int NPHY = 5;
  localparam int HALF = DIV / 2;
  localparam int FRAME_CYC = 64 * DIV;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_in = 1'b1;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_o;
  logic        mdc_o, mdio_o, mdio_oe_o;

  always #10 clk = ~clk;

  mdio_cmd_master #(.CLK_DIV(DIV), .NUM_PHY(NPHY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ctrl_o(ctrl_o), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
    .mdio_i(mdio_in)
  );

  int vectors = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model, updated on each rising edge
  logic        m_act = 0, m_rd = 0;
  int          m_k = 0;
  logic [31:0] m_reg = '0;
  logic [63:0] m_frame = '0;
  logic [15:0] m_rbuf = '0;
  logic [15:0] phy_resp = '0;

  always @(posedge clk) begin : model
    int   b;
    logic go, ok;
    b = m_k / DIV;
    if (!rst_n) begin
      m_act = 0; m_k = 0; m_reg = '0;
    end else if (m_act) begin
      if (m_rd && b >= 48 && (m_k % DIV) == HALF) m_rbuf = {m_rbuf[14:0], mdio_in};
      if (m_k == FRAME_CYC - 1) begin
        m_act = 0; m_reg[31] = 1'b0;
        if (m_rd) m_reg[15:0] = m_rbuf;
      end else m_k++;
    end else if (wr_en) begin
      go = wr_data[31] & wr_data[30];
      ok = (wr_data[25:21] < NPHY);
      m_reg = {1'b0, wr_data[30], 2'b00, wr_data[27], 1'b0, wr_data[25:16], wr_data[15:0]};
      if (go && !ok && wr_data[27]) m_reg[15:0] = 16'hFFFF;
      if (go && ok) begin
        m_act = 1; m_k = 0; m_rd = wr_data[27]; m_reg[31] = 1'b1;
        m_frame = {32'hFFFF_FFFF, 2'b01, (wr_data[27] ? 2'b10 : 2'b01),
                   wr_data[25:16], 2'b10, wr_data[15:0]};
      end
    end
  end

  // per-cycle comparison away from the active edge, then PHY response drive
  always @(negedge clk) begin : cmp
    int   b;
    logic e_mdc, e_oe;
    b     = m_k / DIV;
    e_mdc = m_act && ((m_k % DIV) >= HALF);
    e_oe  = m_act && !(m_rd && b >= 46);
    chk("R6 mdc", {31'b0, mdc_o}, {31'b0, e_mdc});
    chk("R7 oe", {31'b0, mdio_oe_o}, {31'b0, e_oe});
    if (e_oe) chk("R5 mdio bit", {31'b0, mdio_o}, {31'b0, m_frame[63-b]});
    chk("R2 ctrl", ctrl_o, m_reg);
    mdio_in = (m_act && m_rd && b >= 48) ? phy_resp[63-b] : 1'b1;
  end

  function automatic logic [31:0] mk(input bit go, input bit en, input bit rd,
                                     input int phy, input int ra, input logic [15:0] d);
    return {go, en, 2'b00, rd, 1'b0, 5'(phy), 5'(ra), d};
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int busy_n, output int oe_n);
    busy_n = 0; oe_n = 0;
    while (ctrl_o[31] && busy_n < 4 * FRAME_CYC) begin
      busy_n++;
      if (mdio_oe_o) oe_n++;
      @(negedge clk);
    end
  endtask

  initial begin : stim
    int n, oe_n;
    repeat (3) @(negedge clk);
    chk("R1 ctrl reset", ctrl_o, 32'h0);
    chk("R1 mdc reset", {31'b0, mdc_o}, 32'h0);
    chk("R1 oe reset", {31'b0, mdio_oe_o}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // write frame
    wr(mk(1, 1, 0, 1, 3, 16'hA5C3));
    wait_idle(n, oe_n);
    chk("R10 busy length write", n, FRAME_CYC);
    chk("R8 oe cycles write", oe_n, FRAME_CYC);
    chk("R8 data kept", {16'h0, ctrl_o[15:0]}, 32'h0000_A5C3);

    // read frame
    phy_resp = 16'h1234;
    wr(mk(1, 1, 1, 4, 31, 16'h0000));
    wait_idle(n, oe_n);
    chk("R10 busy length read", n, FRAME_CYC);
    chk("R7 oe cycles read", oe_n, 46 * DIV);
    chk("R7 read data", {16'h0, ctrl_o[15:0]}, 32'h0000_1234);

    // write during busy is dropped
    phy_resp = 16'hC3A1;
    wr(mk(1, 1, 1, 2, 9, 16'h5555));
    repeat (40) @(negedge clk);
    wr(mk(1, 1, 0, 0, 1, 16'h7777));
    wait_idle(n, oe_n);
    chk("R3 fields kept", {16'h0, ctrl_o[31:16]}, {16'h0, mk(0, 1, 1, 2, 9, 16'h0) >> 16});
    chk("R3 read data", {16'h0, ctrl_o[15:0]}, 32'h0000_C3A1);

    // absent PHY
    wr(mk(1, 1, 1, NPHY, 2, 16'h0101));
    chk("R9 read absent", ctrl_o, mk(0, 1, 1, NPHY, 2, 16'hFFFF));
    repeat (DIV * 2) @(negedge clk);
    wr(mk(1, 1, 0, 31, 6, 16'h2468));
    chk("R9 write absent", ctrl_o, mk(0, 1, 0, 31, 6, 16'h2468));
    repeat (DIV * 2) @(negedge clk);

    // one flag only
    wr(mk(1, 0, 1, 1, 4, 16'h1357));
    chk("R4 busy w/o enable", ctrl_o, mk(0, 0, 1, 1, 4, 16'h1357));
    repeat (DIV * 3) @(negedge clk);
    chk("R4 still idle", {31'b0, ctrl_o[31]}, 32'h0);
    wr(mk(0, 1, 0, 3, 4, 16'h9ABC));
    chk("R4 enable w/o busy", ctrl_o, mk(0, 1, 0, 3, 4, 16'h9ABC));
    repeat (DIV * 3) @(negedge clk);

    // back-to-back read with edge pattern
    phy_resp = 16'h8001;
    wr(mk(1, 1, 1, 0, 0, 16'hFFFF));
    wait_idle(n, oe_n);
    chk("R10 busy length read2", n, FRAME_CYC);
    chk("R7 read data edges", {16'h0, ctrl_o[15:0]}, 32'h0000_8001);
    wr(mk(1, 1, 0, 4, 17, 16'h0000));
    wait_idle(n, oe_n);
    chk("R8 zero data kept", {16'h0, ctrl_o[15:0]}, 32'h0);
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule